// File: doc/BRIEF.md
# A/B Swallow-Counter Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It divides its input clock by N = 4×B + A. It emits a single-cycle pulse once every N input cycles. Inside, a prescaler counts either 4 or 5 input cycles per step. A B counter counts prescaler steps, one per completed prescaler cycle. An A counter holds the prescaler at modulus 5 for the first A steps of each period, and the prescaler uses modulus 4 for the remaining B − A steps. The total is therefore 5A + 4(B − A) = 4B + A cycles.

One configuration byte carries both words. The block latches it only when a period starts. A period starts at the synchronous reset, at the last cycle of a running period, or on any cycle while the block is halted. Some A/B pairs cannot be produced by the swallow structure. When the latched byte is one of these, the block stops, raises a flag and keeps its output low. It restarts on the first clock that sees a legal byte.

The controller has three states:
- `ST_HALT`: the latched configuration is illegal.
- `ST_SWALLOW`: the prescaler divides by 5 and the A counter is nonzero.
- `ST_MAIN`: the prescaler divides by 4.

It has these transitions:
- **load-swallow**: reset, period end or halt with a legal byte whose A ≠ 0 goes to `ST_SWALLOW`.
- **load-main**: the same cases with A = 0 go to `ST_MAIN`.
- **load-halt**: the same cases with an illegal byte go to `ST_HALT`.
- **swallow-done**: the last modulus-5 step of a period goes from `ST_SWALLOW` to `ST_MAIN`.
- **step**: any other completed prescaler cycle stays in the current state and counts down B, and also A while in `ST_SWALLOW`.

Top module: `ab_feedback_divider`

## Requirements
- R1: The A word is `cfg_word[7:6]` and the B word is `cfg_word[5:0]`. With a legal byte, `div_pulse` is high exactly once in every N = 4×B + A input cycles.
- R2: Every `div_pulse` is exactly one input cycle wide.
- R3: With B = 4, A = 0 and A = 1 are legal (N = 16, 17). A = 2 and A = 3 are illegal.
- R4: With B = 5 or B = 6, A = 0 to 2 are legal (N = 20–22, 24–26). A = 3 is illegal.
- R5: With B ≥ 7, every A from 0 to 3 is legal, up to N = 255 at B = 63, A = 3.
- R6: Any B below 4 is illegal, whatever the value of A.
- R7: While the latched configuration is illegal, `cfg_illegal` is 1 and `div_pulse` stays 0.
- R8: A byte that changes during a period is latched only at that period's last cycle. The running period keeps the old N, and the following period has the new N.
- R9: While `rst` is high, `div_pulse` and `cfg_illegal` are 0 for a legal byte. After release, the first pulse falls in the N-th cycle, counting the first cycle after release as cycle 1.
- R10: From the halted state, a legal byte is latched on the next clock edge. `cfg_illegal` falls in that cycle, and the first pulse follows N cycles after the byte was applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high; restarts a period |
| cfg_word | input | 8 | Division setting: A word in [7:6], B word in [5:0] |
| div_pulse | output | 1 | One-cycle pulse marking the end of each divided period |
| cfg_illegal | output | 1 | High while the latched A/B pair is not producible |

## Verification
The embedded properties check on every cycle that the prescaler count stays within its current modulus, that the remaining A count never exceeds the remaining B count, and that B never reaches zero mid-period. They also check that a running period is never cut short, that pulses never touch each other, and that the halted state is quiet. The exact divide ratio for each legality class, the position of the first pulse after reset or after recovery, and the old-then-new period lengths around a mid-period reconfiguration can only be shown by the bench's directed scenarios. The same holds for finishing the running period before halting on an illegal byte.

// File: rtl/abdiv_pkg.sv
package abdiv_pkg;

    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } div_state_t;

endpackage

// File: rtl/abdiv_legality.sv
module abdiv_legality #(
    parameter int A_W = 2,
    parameter int B_W = 6
) (
    input  logic [A_W-1:0] word_a,
    input  logic [B_W-1:0] word_b,
    output logic           pair_ok
);
    // Smallest B, the two tight B classes and their A ceilings (R3, R4, R6)
    localparam int B_FLOOR  = 4;
    localparam int B_MID_LO = 5;
    localparam int B_MID_HI = 6;
    localparam int A_CAP_FLOOR = 1;
    localparam int A_CAP_MID   = 2;

    always_comb begin
        if (word_b < B_W'(B_FLOOR)) begin
            pair_ok = 1'b0;
        end else if (word_b == B_W'(B_FLOOR)) begin
            pair_ok = (word_a <= A_W'(A_CAP_FLOOR));
        end else if ((word_b >= B_W'(B_MID_LO)) && (word_b <= B_W'(B_MID_HI))) begin
            pair_ok = (word_a <= A_W'(A_CAP_MID));
        end else begin
            pair_ok = 1'b1;   // R5: wide B accepts every A
        end
    end

endmodule

// File: rtl/abdiv_prescaler.sv
module abdiv_prescaler #(
    parameter int PS_LO = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic mod_hi,
    output logic step_done
);
    localparam int PS_HI = PS_LO + 1;
    localparam int CNT_W = $clog2(PS_HI + 1);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (mod_hi) step_done = run && (cnt_q == CNT_W'(PS_HI - 1));
        else        step_done = run && (cnt_q == CNT_W'(PS_LO - 1));
    end

    always_ff @(posedge clk) begin
        if (restart)        cnt_q <= '0;
        else if (step_done) cnt_q <= '0;
        else if (run)       cnt_q <= cnt_q + CNT_W'(1);
    end

    // R1: count never leaves the active modulus
    assert_pre_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= CNT_W'(PS_HI - 1)));
    assert_pre_low_mod_R1: assert property (@(posedge clk) disable iff (rst)
        (run && !mod_hi) |-> (cnt_q <= CNT_W'(PS_LO - 1)));

endmodule

// File: rtl/abdiv_ctrl.sv
module abdiv_ctrl
    import abdiv_pkg::*;
#(
    parameter int A_W = 2,
    parameter int B_W = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] word_a,
    input  logic [B_W-1:0] word_b,
    input  logic           pair_ok,
    input  logic           step_done,
    output logic           restart,
    output logic           mod_hi,
    output logic           run,
    output logic           period_end,
    output logic           halted
);
    div_state_t     state_q, state_d;
    logic [A_W-1:0] a_left_q, a_left_d;
    logic [B_W-1:0] b_left_q, b_left_d;

    // Output process
    always_comb begin
        run        = (state_q != ST_HALT);
        mod_hi     = (state_q == ST_SWALLOW);
        halted     = (state_q == ST_HALT);
        period_end = run && step_done && (b_left_q == B_W'(1));
        restart    = rst || period_end || halted;
    end

    // Next-state process
    always_comb begin
        state_d  = state_q;
        a_left_d = a_left_q;
        b_left_d = b_left_q;
        if (restart) begin
            if (pair_ok) begin
                a_left_d = word_a;
                b_left_d = word_b;
                state_d  = (word_a != '0) ? ST_SWALLOW : ST_MAIN;
            end else begin
                state_d  = ST_HALT;
            end
        end else begin
            unique case (state_q)
                ST_SWALLOW: begin
                    if (step_done) begin
                        a_left_d = a_left_q - A_W'(1);
                        b_left_d = b_left_q - B_W'(1);
                        state_d  = (a_left_q == A_W'(1)) ? ST_MAIN : ST_SWALLOW;
                    end
                end
                ST_MAIN: begin
                    if (step_done) b_left_d = b_left_q - B_W'(1);
                end
                ST_HALT: begin
                    state_d = ST_HALT;
                end
                default: state_d = ST_HALT;
            endcase
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        state_q  <= state_d;
        a_left_q <= a_left_d;
        b_left_q <= b_left_d;
    end

    // R1: swallow count never exceeds remaining steps; B never empties mid-run
    assert_swallow_bound_R1: assert property (@(posedge clk) disable iff (rst)
        run |-> ({{B_W{1'b0}}, a_left_q} <= {{A_W{1'b0}}, b_left_q}));
    assert_b_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
        run |-> (b_left_q != '0));
    // R2: pulses never adjoin
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        period_end |=> !period_end);
    // R8: a running period cannot be abandoned before its end
    assert_no_truncation_R8: assert property (@(posedge clk) disable iff (rst)
        (run && !period_end) |=> run);

endmodule

// File: rtl/ab_feedback_divider.sv
module ab_feedback_divider #(
    parameter int A_W   = 2,
    parameter int B_W   = 6,
    parameter int PS_LO = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [A_W+B_W-1:0]   cfg_word,
    output logic                 div_pulse,
    output logic                 cfg_illegal
);
    localparam int CFG_W = A_W + B_W;

    logic [A_W-1:0] word_a;
    logic [B_W-1:0] word_b;
    logic pair_ok, step_done, restart, mod_hi, run, period_end, halted;

    assign word_a = cfg_word[CFG_W-1:B_W];
    assign word_b = cfg_word[B_W-1:0];

    abdiv_legality #(.A_W(A_W), .B_W(B_W)) u_legal (
        .word_a (word_a),
        .word_b (word_b),
        .pair_ok(pair_ok)
    );

    abdiv_prescaler #(.PS_LO(PS_LO)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .run      (run),
        .mod_hi   (mod_hi),
        .step_done(step_done)
    );

    abdiv_ctrl #(.A_W(A_W), .B_W(B_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .word_a    (word_a),
        .word_b    (word_b),
        .pair_ok   (pair_ok),
        .step_done (step_done),
        .restart   (restart),
        .mod_hi    (mod_hi),
        .run       (run),
        .period_end(period_end),
        .halted    (halted)
    );

    always_comb begin
        div_pulse   = period_end;
        cfg_illegal = halted;
    end

    // R7: halted block stays silent
    assert_quiet_when_illegal_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_illegal |-> !div_pulse);

endmodule

// File: tb/tb_ab_feedback_divider.sv
module tb_ab_feedback_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_word = 8'h0A;
    logic       div_pulse, cfg_illegal;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ab_feedback_divider dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_word   (cfg_word),
        .div_pulse  (div_pulse),
        .cfg_illegal(cfg_illegal)
    );

    function automatic logic [7:0] mk(input int a, input int b);
        return {a[1:0], b[5:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input int a, input int b);
        @(negedge clk);
        cfg_word = mk(a, b);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // R9: outputs quiet during reset with a legal byte
    task automatic t_reset_state();
        int bad = 0;
        @(negedge clk);
        cfg_word = mk(1, 10);
        rst = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (div_pulse || cfg_illegal) bad++;
        end
        chk(bad == 0, "R9 reset quiet", bad, 0);
        rst = 1'b0;
    endtask

    // Legal ratio: first pulse, two intervals, width, flag
    task automatic t_ratio(input int a, input int b, input string req);
        int n = 4 * b + a;
        int prev = -1, cnt = 0, wide = 0, flag_bad = 0;
        bit lastp = 1'b0;
        do_reset(a, b);
        for (int i = 1; i <= 3 * n + 1; i++) begin
            tick();
            if (cfg_illegal) flag_bad++;
            if (div_pulse && lastp) wide++;
            if (div_pulse) begin
                if (cnt == 0) chk(i == n - 1, {req, " R9 first pulse"}, i, n - 1);
                else          chk(i - prev == n, {req, " R1 interval"}, i - prev, n);
                prev = i;
                cnt++;
            end
            lastp = div_pulse;
        end
        chk(cnt == 3, {req, " R1 pulse count"}, cnt, 3);
        chk(wide == 0, {req, " R2 width"}, wide, 0);
        chk(flag_bad == 0, {req, " flag low"}, flag_bad, 0);
    endtask

    // Illegal pair: flag high, no pulses
    task automatic t_illegal(input int a, input int b, input string req);
        int pulses = 0, flag_low = 0;
        do_reset(a, b);
        for (int i = 1; i <= 300; i++) begin
            tick();
            if (div_pulse) pulses++;
            if (!cfg_illegal) flag_low++;
        end
        chk(flag_low == 0, {req, " R7 flag high"}, flag_low, 0);
        chk(pulses == 0, {req, " R7 output low"}, pulses, 0);
    endtask

    // R8: change mid-period, old N completes, then new N
    task automatic t_reconfig();
        int idx[3];
        int cnt = 0;
        do_reset(1, 10);               // N = 41
        for (int i = 1; i <= 170; i++) begin
            tick();
            if (div_pulse && cnt < 3) begin
                idx[cnt] = i;
                cnt++;
            end
            if (i == 47) cfg_word = mk(3, 20);   // N = 83
        end
        chk(cnt == 3, "R8 pulse count", cnt, 3);
        chk(idx[0] == 40, "R8 first", idx[0], 40);
        chk(idx[1] == 81, "R8 old N kept", idx[1], 81);
        chk(idx[2] == 164, "R8 new N", idx[2], 164);
    endtask

    // R7/R8: illegal byte mid-period finishes the period, then halts
    task automatic t_bad_at_boundary();
        int late = 0;
        do_reset(0, 7);                // N = 28
        for (int i = 1; i <= 150; i++) begin
            tick();
            if (i == 27) begin
                chk(div_pulse == 1'b1, "R8 period completes", int'(div_pulse), 1);
                chk(cfg_illegal == 1'b0, "R8 flag before boundary", int'(cfg_illegal), 0);
            end
            if (i == 28) chk(cfg_illegal == 1'b1, "R7 flag at boundary", int'(cfg_illegal), 1);
            if (i >= 28 && div_pulse) late++;
            if (i == 10) cfg_word = mk(0, 3);
        end
        chk(late == 0, "R7 no pulse after halt", late, 0);
    endtask

    // R10: recovery from halt
    task automatic t_recover();
        int first = -1, second = -1;
        do_reset(0, 2);
        repeat (5) tick();
        chk(cfg_illegal == 1'b1, "R10 halted", int'(cfg_illegal), 1);
        cfg_word = mk(0, 8);           // N = 32
        for (int i = 1; i <= 70; i++) begin
            tick();
            if (i == 1) chk(cfg_illegal == 1'b0, "R10 flag falls", int'(cfg_illegal), 0);
            if (div_pulse) begin
                if (first < 0) first = i;
                else if (second < 0) second = i;
            end
        end
        chk(first == 32, "R10 first pulse", first, 32);
        chk(second == 64, "R10 second pulse", second, 64);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_ratio(0, 4, "R3");
        t_ratio(1, 4, "R3");
        t_ratio(0, 5, "R4");
        t_ratio(2, 5, "R4");
        t_ratio(2, 6, "R4");
        t_ratio(0, 7, "R5");
        t_ratio(3, 7, "R5");
        t_ratio(1, 10, "R1");
        t_ratio(3, 63, "R5");
        t_illegal(2, 4, "R3");
        t_illegal(3, 4, "R3");
        t_illegal(3, 5, "R4");
        t_illegal(3, 6, "R4");
        t_illegal(0, 3, "R6");
        t_illegal(1, 0, "R6");
        t_reconfig();
        t_bad_at_boundary();
        t_recover();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule